// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs the two-wire station management protocol that a MAC uses to read and write the configuration registers of an external Ethernet PHY. Software first writes a word that holds the target PHY address and register number. It then starts a transfer in one of two ways: writing the write-data register sends a write frame carrying that 16-bit value, and setting the read bit in the command register sends a read frame. A busy flag stays high for the whole frame. Software polls this flag and, once it has dropped, takes the returned value from the read-data output.

The management clock is generated from the system clock. A programmable half-period count sets its frequency, and the default of 25 gives divide-by-50. Every frame carries 64 bit times: 32 preamble ones, start code 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register address, two turnaround bits, and 16 data bits, all sent MSB first. The data line changes as the management clock falls and is sampled as it rises. During the turnaround and data of a read the master releases the line so that the PHY can drive it. Setting the management-reset bit drops any frame in progress and holds the block idle until the bit is cleared.

Register select codes: 0 = address word (PHY address in bits 12:8, register address in bits 4:0), 1 = write data, 2 = command (bit 0 = read), 3 = configuration (bits 7:0 = half-period count in system clocks, 0 treated as 1; bit 15 = management reset).

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset, busy, the management clock, the output enable and the read data are all 0, and the idle data line is 1.
- R2: A write to select 1 while the block is idle starts a write frame. Busy goes high at the clock edge that accepts the write and stays high for exactly 128×H system clocks, where H is the effective half-period count.
- R3: A write frame, sampled at the 64 rising management-clock edges, reads 32 ones, 01, 01, the PHY address (address word bits 12:8), the register address (bits 4:0), 10, then the 16 data bits MSB first, with the output enable high throughout.
- R4: Writing select 2 with bit 0 = 1 while the stored read bit is 0 starts a read frame: 32 ones, 01, 10, PHY address, register address. The output enable is high for the first 46 bit times and low for the last 18.
- R5: During the last 16 bit times of a read, the data input is sampled at each rising management-clock edge, MSB first. The value is placed on the read-data output no later than the edge where busy falls, and the read data changes at no other time.
- R6: The management clock is low whenever busy is low. While busy is high it toggles every H system clocks, with H = configuration bits 7:0 (0 acts as 1). The reset value is H = 25.
- R7: While a frame is in progress, the data output changes only at a falling edge of the management clock.
- R8: Writes to select 1 or to the read bit while busy is high do not change the frame in progress or its length.
- R9: Writing select 2 with bit 0 = 1 when the stored read bit is already 1 starts no frame. The bit must first be written 0.
- R10: Setting configuration bit 15 ends any frame. By the second clock edge after the write, busy, the management clock and the output enable are all 0. Triggers are ignored while the bit is set, and after it is cleared a new frame runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 address, 1 write data, 2 command, 3 configuration) |
| cfg_wdata_i | input | 16 | Register write value |
| busy_o | output | 1 | Frame in progress |
| rd_data_o | output | 16 | Value returned by the last read frame |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
Most internal faults in this block show up in the bit stream seen at rising management-clock edges. A wrong bit counter shifts or truncates the frame and changes the busy length. This is visible within a single frame, and the busy length differs by a multiple of 2×H cycles. A divider fault changes the length of every frame from the first one. A wrong read-sample window shows up only in the returned word after busy drops. Abort and retrigger faults appear within two clocks of the configuration write, or as a frame starting that should not.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = 64;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int PRE_LEN   = 32;
    // first bit time the master releases the line in a read
    localparam int TURN_FIRST = PRE_LEN + 2 + 2 + PHY_W + REG_W;
    // first bit time of the data field
    localparam int DATA_FIRST = TURN_FIRST + 2;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_CFG   = 2'd3
    } mgmt_sel_e;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } mgmt_op_e;

endpackage

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int HALF_DEFAULT = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         sel_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               busy_i,
    output logic               start_o,
    output mgmt_op_e           start_op_o,
    output logic [PHY_W-1:0]   phy_o,
    output logic [REG_W-1:0]   reg_o,
    output logic [DATA_W-1:0]  data_o,
    output logic [DIV_W-1:0]   half_o,
    output logic               mrst_o
);

    localparam int MRST_BIT = DATA_W - 1;
    localparam int PHY_LSB  = 8;

    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] data;
        logic              rd_bit;
        logic [DIV_W-1:0]  half;
        logic              mrst;
    } regs_t;

    regs_t    st_d, st_q;
    logic     start_c;
    mgmt_op_e op_c;

    always_comb begin
        st_d    = st_q;
        start_c = 1'b0;
        op_c    = OP_WR;
        if (wr_i) begin
            case (sel_i)
                SEL_ADDR: begin
                    st_d.phy   = wdata_i[PHY_LSB +: PHY_W];
                    st_d.regad = wdata_i[REG_W-1:0];
                end
                SEL_WDATA: begin
                    if (!busy_i && !st_q.mrst) begin
                        st_d.data = wdata_i;
                        start_c   = 1'b1;
                        op_c      = OP_WR;
                    end
                end
                SEL_CMD: begin
                    st_d.rd_bit = wdata_i[0];
                    if (wdata_i[0] && !st_q.rd_bit && !busy_i && !st_q.mrst) begin
                        start_c = 1'b1;
                        op_c    = OP_RD;
                    end
                end
                default: begin
                    st_d.half = wdata_i[DIV_W-1:0];
                    st_d.mrst = wdata_i[MRST_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.half   <= DIV_W'(HALF_DEFAULT);
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o    = start_c;
    assign start_op_o = op_c;
    assign phy_o      = st_q.phy;
    assign reg_o      = st_q.regad;
    assign data_o     = st_d.data;
    assign half_o     = st_q.half;
    assign mrst_o     = st_q.mrst;

    // R9: a launch of a read never happens while the stored read bit is set
    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && start_op_o == OP_RD) |=> st_q.rd_bit);

endmodule

// File: rtl/phy_mgmt_clkgen.sv
module phy_mgmt_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t             st_d, st_q;
    logic [DIV_W-1:0] half_eff;
    logic             wrap;

    always_comb begin
        half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
        wrap     = run_i && (st_q.cnt == half_eff - DIV_W'(1));
        st_d     = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = wrap && !st_q.mdc;
    assign fall_o = wrap &&  st_q.mdc;

    // R6: the clock never moves while the divider is stopped
    p_still_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.mdc);

endmodule

// File: rtl/phy_mgmt_frame.sv
module phy_mgmt_frame
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  mgmt_op_e          op_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              abort_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic                 busy;
        mgmt_op_e             op;
        logic [FRAME_LEN-1:0] frame;
        logic [CNT_W-1:0]     bitn;
        logic [DATA_W-1:0]    rdsh;
        logic [DATA_W-1:0]    rdat;
    } frm_t;

    frm_t st_d, st_q;
    logic [FRAME_LEN-1:0] load_c;

    always_comb begin
        load_c = {{PRE_LEN{1'b1}}, 2'b01,
                  (op_i == OP_RD) ? 2'b10 : 2'b01,
                  phy_i, reg_i,
                  (op_i == OP_RD) ? 2'b11 : 2'b10,
                  (op_i == OP_RD) ? {DATA_W{1'b1}} : data_i};
        st_d = st_q;
        if (abort_i) begin
            st_d.busy = 1'b0;
            st_d.bitn = '0;
        end else if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.op    = op_i;
                st_d.frame = load_c;
                st_d.bitn  = '0;
                st_d.rdsh  = '0;
            end
        end else begin
            if (rise_i && st_q.op == OP_RD && st_q.bitn >= CNT_W'(DATA_FIRST))
                st_d.rdsh = {st_q.rdsh[DATA_W-2:0], mdio_i};
            if (fall_i) begin
                if (st_q.bitn == CNT_W'(FRAME_LEN - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.bitn = '0;
                    if (st_q.op == OP_RD) st_d.rdat = st_q.rdsh;
                end else begin
                    st_d.bitn  = st_q.bitn + CNT_W'(1);
                    st_d.frame = {st_q.frame[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign mdio_o    = st_q.busy ? st_q.frame[FRAME_LEN-1] : 1'b1;
    assign mdio_oe_o = st_q.busy &&
                       (st_q.op == OP_WR || st_q.bitn < CNT_W'(TURN_FIRST));
    assign rd_data_o = st_q.rdat;

    // R5: returned data only moves at the end of a frame
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(st_q.busy) |-> $stable(st_q.rdat));

    // R4: line released whenever the bit counter passes into turnaround of a read
    p_release_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_RD && $past(st_q.busy) &&
         $past(st_q.bitn) == CNT_W'(TURN_FIRST - 1) && st_q.bitn == CNT_W'(TURN_FIRST))
        |-> !mdio_oe_o && $past(mdio_oe_o));

endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
    import phy_mgmt_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int HALF_DEFAULT = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_i,
    input  logic [1:0]  cfg_sel_i,
    input  logic [15:0] cfg_wdata_i,
    output logic        busy_o,
    output logic [15:0] rd_data_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);

    logic              start_w;
    mgmt_op_e          op_w;
    logic [PHY_W-1:0]  phy_w;
    logic [REG_W-1:0]  reg_w;
    logic [DATA_W-1:0] data_w;
    logic [DIV_W-1:0]  half_w;
    logic              mrst_w;
    logic              rise_w, fall_w, busy_w, run_w;

    phy_mgmt_regs #(.DIV_W(DIV_W), .HALF_DEFAULT(HALF_DEFAULT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .busy_i     (busy_w),
        .start_o    (start_w),
        .start_op_o (op_w),
        .phy_o      (phy_w),
        .reg_o      (reg_w),
        .data_o     (data_w),
        .half_o     (half_w),
        .mrst_o     (mrst_w)
    );

    assign run_w = busy_w && !mrst_w;

    phy_mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .half_i (half_w),
        .mdc_o  (mdc_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    phy_mgmt_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .op_i      (op_w),
        .phy_i     (phy_w),
        .reg_i     (reg_w),
        .data_i    (data_w),
        .rise_i    (rise_w),
        .fall_i    (fall_w),
        .abort_i   (mrst_w),
        .mdio_i    (mdio_i),
        .busy_o    (busy_w),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .rd_data_o (rd_data_o)
    );

    assign busy_o = busy_w;

    // R6: management clock idles low
    p_idle_mdc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);

    // R7: data output only moves on a falling management clock
    p_mdio_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !($past(mdc_o) && !mdc_o)) |-> $stable(mdio_o));

    // R2: a frame only begins on an accepted register write
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cfg_wr_i));

    // R10: management reset held means no frame
    p_mrst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst_w && $past(mrst_w)) |-> (!busy_o && !mdio_oe_o));

endmodule

// File: tb/phy_mgmt_master_tb.sv
module phy_mgmt_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        busy, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    phy_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .busy_o(busy), .rd_data_o(rd_data),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // ---------------- port monitor and PHY responder ----------------
    logic [63:0] cap_bits, cap_oe;
    int          rise_cnt = 0;
    int          busy_cyc = 0;
    int          r7_bad   = 0;
    logic        mdc_p = 1'b0, busy_p = 1'b0, mo_p = 1'b1;
    logic [15:0] resp_word = 16'd0;

    assign mdio_i = (rise_cnt >= 48 && rise_cnt < 64) ? resp_word[63 - rise_cnt] : 1'b1;

    always @(negedge clk) begin
        if (busy && !busy_p) begin
            rise_cnt = 0;
            busy_cyc = 0;
            cap_bits = '0;
            cap_oe   = '0;
        end
        if (busy) busy_cyc++;
        if (mdc && !mdc_p && rise_cnt < 64) begin
            cap_bits[63 - rise_cnt] = mdio_o;
            cap_oe[63 - rise_cnt]   = mdio_oe;
            rise_cnt++;
        end
        if (busy && busy_p && (mdio_o != mo_p) && !(mdc_p && !mdc)) r7_bad++;
        mdc_p  = mdc;
        busy_p = busy;
        mo_p   = mdio_o;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10000 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
    endfunction

    // compare the frame seen at the pins with the expectation
    task automatic check_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] d, input int half);
        logic [63:0] ef, eoe, mask;
        int h;
        h    = (half == 0) ? 1 : half;
        ef   = exp_frame(rd, phy, rg, d);
        eoe  = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        mask = eoe;
        check(rise_cnt == 64, "R3 rising edge count", 64'(rise_cnt), 64'd64);
        if (rd) begin
            check((cap_bits & mask) == (ef & mask), "R4 read frame bits", cap_bits & mask, ef & mask);
            check(cap_oe == eoe, "R4 read output enable", cap_oe, eoe);
        end else begin
            check(cap_bits == ef, "R3 write frame bits", cap_bits, ef);
            check(cap_oe == eoe, "R3 write output enable", cap_oe, eoe);
        end
        check(busy_cyc == 128 * h, "R2 R6 busy length", 64'(busy_cyc), 64'(128 * h));
        check(r7_bad == 0, "R7 data moved off falling edge", 64'(r7_bad), 64'd0);
    endtask

    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input logic [15:0] resp, input int half);
        cfg_write(2'd3, 16'(half));
        cfg_write(2'd0, {3'b000, phy, 3'b000, rg});
        resp_word = resp;
        if (rd) cfg_write(2'd2, 16'h0001);
        else    cfg_write(2'd1, d);
        wait_idle();
        check_frame(rd, phy, rg, d, half);
        if (rd) begin
            check(rd_data == resp, "R5 read data", 64'(rd_data), 64'(resp));
            cfg_write(2'd2, 16'h0000);
        end
    endtask

    // op, phy, reg, write data, response, half period
    localparam int NVEC = 6;
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000, 8'd1},
        {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3, 8'd2},
        {1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0000, 8'd3},
        {1'b1, 5'h0A, 5'h02, 16'h0000, 16'h0001, 8'd0},
        {1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0000, 8'd2},
        {1'b1, 5'h03, 5'h11, 16'h0000, 16'h8000, 8'd1}
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !mdc && !mdio_oe && rd_data == 16'd0 && mdio_o,
              "R1 reset state", {busy, mdc, mdio_oe, mdio_o, rd_data},
              {4'b0001, 16'h0000});

        // R6 default divider (H = 25) on a write frame
        cfg_write(2'd0, 16'h0405);
        cfg_write(2'd1, 16'hC0DE);
        wait_idle();
        check_frame(1'b0, 5'h04, 5'h05, 16'hC0DE, 25);

        // table of transactions
        for (int v = 0; v < NVEC; v++) begin
            run_txn(VEC[v][50], VEC[v][49:45], VEC[v][44:40], VEC[v][39:24],
                    VEC[v][23:8], int'(VEC[v][7:0]));
        end

        // R8 triggers while busy are ignored
        cfg_write(2'd3, 16'd2);
        cfg_write(2'd0, 16'h0203);
        cfg_write(2'd1, 16'hBEEF);
        repeat (20) @(negedge clk);
        cfg_write(2'd1, 16'h0F0F);
        cfg_write(2'd2, 16'h0001);
        wait_idle();
        check_frame(1'b0, 5'h02, 5'h03, 16'hBEEF, 2);
        cfg_write(2'd2, 16'h0000);
        repeat (3) @(negedge clk);
        check(!busy, "R8 no frame after clearing read bit", 64'(busy), 64'd0);

        // R9 rewriting a set read bit does not relaunch
        cfg_write(2'd0, 16'h0107);
        resp_word = 16'h3C5A;
        cfg_write(2'd2, 16'h0001);
        wait_idle();
        check(rd_data == 16'h3C5A, "R5 read data before R9", 64'(rd_data), 64'h3C5A);
        held = rd_data;
        cfg_write(2'd2, 16'h0001);
        repeat (10) @(negedge clk);
        check(!busy && rd_data == held, "R9 no relaunch", {busy, rd_data}, {1'b0, held});
        cfg_write(2'd2, 16'h0000);
        resp_word = 16'h6006;
        cfg_write(2'd2, 16'h0001);
        check(busy, "R9 relaunch after clear", 64'(busy), 64'd1);
        wait_idle();
        check(rd_data == 16'h6006, "R9 R5 second read data", 64'(rd_data), 64'h6006);
        cfg_write(2'd2, 16'h0000);

        // R10 management reset aborts and blocks
        cfg_write(2'd3, 16'd3);
        cfg_write(2'd1, 16'h5555);
        repeat (30) @(negedge clk);
        check(busy, "R10 frame running before abort", 64'(busy), 64'd1);
        cfg_write(2'd3, 16'h8003);
        @(negedge clk);
        check(!busy && !mdc && !mdio_oe, "R10 abort", {busy, mdc, mdio_oe}, 3'b000);
        cfg_write(2'd1, 16'hAAAA);
        repeat (5) @(negedge clk);
        check(!busy && !mdc, "R10 trigger ignored under reset", {busy, mdc}, 2'b00);
        cfg_write(2'd3, 16'd3);
        run_txn(1'b0, 5'h11, 5'h09, 16'h9876, 16'h0000, 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule